// File: doc/BRIEF.md
# Dual-Port Conversion Result Register

This block models the digital output stage of a sampling converter. A convert command latches a stimulus sample, which stands in for the analog conversion. A busy window of fixed length follows. When the ready flag rises again, the formatted result is published. The result can then be read in two ways, and the two reads do not interfere. The parallel read is non-destructive. The serial read shifts a separate output shift register one bit per data clock.

The result is coded as straight binary or as two's complement. The two codes differ only in the inverted top bit. In serial mode the bits are clocked by an external data clock. In internal-clock mode, the block streams the previous result by itself while the next conversion runs, and drives its own bit clock. For parallel-only use, hold the external data clock low and the serial clock-source select high.

Top module: `adc_result_port`

## Requirements
- R1: After a synchronous reset, the outputs are as follows: `rdy` high, `pdata_oe` low, `pdata` zero, `sdata` low and `sclk_out` low. Both the result and the shift register are cleared.
- R2: A conversion starts at the first clock edge where the OR of `sel_n` and `conv_n` is low after having been high at the previous edge, while `rdy` is high. Either input may go low first. `rdy` is low from that edge for exactly CONV_CYCLES edges and rises at the CONV_CYCLES-th edge after the start.
- R3: A convert command that arrives while `rdy` is low is ignored. It neither stretches the busy window nor replaces the captured sample.
- R4: The result published when `rdy` rises is built from the `sample_in` and `fmt_sb` values present at the start edge. Later changes to those inputs have no effect on it.
- R5: With `fmt_sb` high the code is straight binary and equals the sample. With `fmt_sb` low the code is two's complement, which is the sample with bit 11 inverted. Examples: FFF gives 7FF, 800 gives 000, 7FF gives FFF, 000 gives 800.
- R6: One edge after `sel_n` is low and `conv_n` is high, `pdata_oe` is high and `pdata` carries the current result. Otherwise, one edge later, `pdata_oe` is low and `pdata` is zero.
- R7: A parallel read does not alter the result or the serial shift register, and repeated reads return the same word. Serial shifting does not alter the parallel word.
- R8: With `serial_ext` high, each rising edge of `sclk_ext` seen at a clock edge shifts the register left by one and fills a zero. `sdata` is always the register's MSB, so the word leaves MSB first.
- R9: When a conversion starts with `serial_ext` low, the register contents (the previous result) are streamed MSB first. Each bit is held for BIT_CYCLES cycles, and `sclk_out` is high in the second half of each bit. After 12 bits `sclk_out` stays low.
- R10: Completion of a conversion reloads the shift register with the new result, whatever shifting happened before.
- R11: With `serial_ext` low and no stream running, `sclk_ext` pulses leave the shift register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low select; ORed with `conv_n` for convert |
| conv_n | input | 1 | Low requests convert, high requests parallel read |
| sample_in | input | 12 | Stimulus sample in straight binary |
| fmt_sb | input | 1 | 1 straight binary, 0 two's complement |
| serial_ext | input | 1 | 1 external data clock, 0 internal stream |
| sclk_ext | input | 1 | External serial data clock |
| rdy | output | 1 | High when idle, low during a conversion |
| pdata_oe | output | 1 | Parallel bus driven |
| pdata | output | 12 | Parallel result, zero when not driven |
| sdata | output | 1 | Serial data, MSB of the shift register |
| sclk_out | output | 1 | Internal bit clock during streaming |

## Verification
The ready flag falls one edge after the convert condition is first seen, and rises CONV_CYCLES edges after that. The bench checks it at the edge just before the rise and at the rise itself. The parallel word and its enable appear one edge after the read condition, so every parallel check follows an extra clock edge. A serial shift takes effect at the same edge where the raised `sclk_ext` is sampled. Internal-stream bits change every BIT_CYCLES edges, and the bench checks each bit half at its exact edge. All inputs are driven and all outputs are sampled 2 ns after a rising edge.

// File: rtl/adcout_pkg.sv
package adcout_pkg;

    localparam int RES_W = 12;

    typedef logic [RES_W-1:0] code_t;

    typedef enum logic {
        SER_IDLE = 1'b0,
        SER_RUN  = 1'b1
    } ser_state_e;

    typedef struct packed {
        code_t raw;
        logic  sb;
    } capt_t;

    // Straight binary passes through; two's complement flips the top bit.
    function automatic code_t fmt_code(code_t raw, logic sb);
        code_t c;
        c = raw;
        if (!sb) c[RES_W-1] = ~raw[RES_W-1];
        return c;
    endfunction

endpackage

// File: rtl/adcout_conv_seq.sv
module adcout_conv_seq
    import adcout_pkg::*;
#(
    parameter int CONV_CYCLES = 32
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  sel_n,
    input  logic  conv_n,
    input  code_t sample_in,
    input  logic  fmt_sb,
    output logic  rdy,
    output logic  start,
    output logic  done,
    output code_t load_val,
    output code_t result
);
    localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;

    logic             trig;
    logic             trig_q;
    logic             busy;
    logic [CNT_W-1:0] cnt;
    capt_t            cap_q;

    assign trig     = sel_n | conv_n;
    assign start    = !busy && trig_q && !trig;
    assign done     = busy && (cnt == CNT_W'(CONV_CYCLES - 1));
    assign load_val = fmt_code(cap_q.raw, cap_q.sb);
    assign rdy      = !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q <= 1'b1;
            busy   <= 1'b0;
            cnt    <= '0;
            cap_q  <= '0;
            result <= '0;
        end else begin
            trig_q <= trig;
            if (start) begin
                busy  <= 1'b1;
                cnt   <= '0;
                cap_q <= '{raw: sample_in, sb: fmt_sb};
            end else if (busy) begin
                if (done) begin
                    busy   <= 1'b0;
                    result <= load_val;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R2: an accepted start drops ready at the next edge
    p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
        start |=> !rdy);

    // R3: commands during a conversion neither end it nor replace the capture
    p_ignore_busy_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> (!rdy && $stable(cap_q)));

    // R4: the published result moves only at completion
    p_result_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(result));

endmodule

// File: rtl/adcout_ser_shift.sv
module adcout_ser_shift
    import adcout_pkg::*;
#(
    parameter int BIT_CYCLES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  done,
    input  code_t load_val,
    input  logic  serial_ext,
    input  logic  sclk_ext,
    output logic  sdata,
    output logic  sclk_out
);
    localparam int PH_W  = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;
    localparam int IDX_W = $clog2(RES_W);

    code_t            shreg;
    logic             sclk_q;
    logic             ext_edge;
    ser_state_e       st;
    logic [PH_W-1:0]  phase;
    logic [IDX_W-1:0] idx;

    assign ext_edge = serial_ext && sclk_ext && !sclk_q;
    assign sdata    = shreg[RES_W-1];
    assign sclk_out = (st == SER_RUN) && (phase >= PH_W'(BIT_CYCLES / 2));

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '0;
            sclk_q <= 1'b0;
            st     <= SER_IDLE;
            phase  <= '0;
            idx    <= '0;
        end else begin
            sclk_q <= sclk_ext;
            if (done) begin
                shreg <= load_val;
                st    <= SER_IDLE;
            end else if (st == SER_RUN) begin
                if (phase == PH_W'(BIT_CYCLES - 1)) begin
                    phase <= '0;
                    shreg <= {shreg[RES_W-2:0], 1'b0};
                    if (idx == IDX_W'(RES_W - 1)) st <= SER_IDLE;
                    else idx <= idx + 1'b1;
                end else begin
                    phase <= phase + 1'b1;
                end
            end else if (start && !serial_ext) begin
                st    <= SER_RUN;
                phase <= '0;
                idx   <= '0;
            end else if (ext_edge) begin
                shreg <= {shreg[RES_W-2:0], 1'b0};
            end
        end
    end

    // R8: one external clock edge moves the word one place toward the MSB
    p_ext_shift_r8: assert property (@(posedge clk) disable iff (rst)
        (ext_edge && st == SER_IDLE && !done) |=>
            (shreg == {$past(shreg[RES_W-2:0]), 1'b0}));

    // R10: completion reloads the shift register
    p_reload_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> (shreg == $past(load_val)));

    // R11: with the external clock deselected and no stream, nothing shifts
    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!serial_ext && st == SER_IDLE && !done) |=> $stable(shreg));

    // R9: a stream never counts past the last bit
    p_idx_range_r9: assert property (@(posedge clk) disable iff (rst)
        (st == SER_RUN) |-> (idx <= IDX_W'(RES_W - 1)));

endmodule

// File: rtl/adcout_par_port.sv
module adcout_par_port
    import adcout_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sel_n,
    input  logic  conv_n,
    input  code_t result,
    output logic  pdata_oe,
    output code_t pdata
);
    logic rd_en;

    assign rd_en = !sel_n && conv_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            pdata_oe <= 1'b0;
            pdata    <= '0;
        end else begin
            pdata_oe <= rd_en;
            pdata    <= rd_en ? result : '0;
        end
    end

    // R6: an undriven bus reads as zero
    p_float_zero_r6: assert property (@(posedge clk) disable iff (rst)
        !pdata_oe |-> (pdata == '0));

    // R7: back-to-back reads of an unchanged result return the same word
    p_reread_r7: assert property (@(posedge clk) disable iff (rst)
        (pdata_oe && $stable(result)) |=> (!pdata_oe || $stable(pdata)));

endmodule

// File: rtl/adc_result_port.sv
module adc_result_port
    import adcout_pkg::*;
#(
    parameter int CONV_CYCLES = 32,
    parameter int BIT_CYCLES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              conv_n,
    input  logic [RES_W-1:0]  sample_in,
    input  logic              fmt_sb,
    input  logic              serial_ext,
    input  logic              sclk_ext,
    output logic              rdy,
    output logic              pdata_oe,
    output logic [RES_W-1:0]  pdata,
    output logic              sdata,
    output logic              sclk_out
);
    logic  start;
    logic  done;
    code_t load_val;
    code_t result;

    adcout_conv_seq #(.CONV_CYCLES(CONV_CYCLES)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .sel_n     (sel_n),
        .conv_n    (conv_n),
        .sample_in (sample_in),
        .fmt_sb    (fmt_sb),
        .rdy       (rdy),
        .start     (start),
        .done      (done),
        .load_val  (load_val),
        .result    (result)
    );

    adcout_ser_shift #(.BIT_CYCLES(BIT_CYCLES)) u_ser (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .done       (done),
        .load_val   (load_val),
        .serial_ext (serial_ext),
        .sclk_ext   (sclk_ext),
        .sdata      (sdata),
        .sclk_out   (sclk_out)
    );

    adcout_par_port u_par (
        .clk      (clk),
        .rst      (rst),
        .sel_n    (sel_n),
        .conv_n   (conv_n),
        .result   (result),
        .pdata_oe (pdata_oe),
        .pdata    (pdata)
    );

    // R1: idle and quiet on the first cycle after reset
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (rdy && !pdata_oe && !sclk_out));

endmodule

// File: tb/adc_result_port_test.sv
module adc_result_port_test;
    localparam int CONV = 32;
    localparam int BITC = 2;
    localparam int NV   = 10;

    // {fmt_sb, sample}
    localparam logic [12:0] VEC [NV] = '{
        {1'b1, 12'hFFF}, {1'b1, 12'h800}, {1'b1, 12'h7FF}, {1'b1, 12'h000},
        {1'b0, 12'hFFF}, {1'b0, 12'h800}, {1'b0, 12'h7FF}, {1'b0, 12'h000},
        {1'b1, 12'hA5C}, {1'b0, 12'h3C1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_n = 1'b1;
    logic        conv_n = 1'b1;
    logic [11:0] sample_in = '0;
    logic        fmt_sb = 1'b1;
    logic        serial_ext = 1'b1;
    logic        sclk_ext = 1'b0;
    logic        rdy, pdata_oe, sdata, sclk_out;
    logic [11:0] pdata;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    adc_result_port #(.CONV_CYCLES(CONV), .BIT_CYCLES(BITC)) uut (
        .clk(clk), .rst(rst), .sel_n(sel_n), .conv_n(conv_n),
        .sample_in(sample_in), .fmt_sb(fmt_sb), .serial_ext(serial_ext),
        .sclk_ext(sclk_ext), .rdy(rdy), .pdata_oe(pdata_oe), .pdata(pdata),
        .sdata(sdata), .sclk_out(sclk_out)
    );

    function automatic logic [11:0] exp_code(logic [11:0] s, logic sb);
        return sb ? s : (s ^ 12'h800);
    endfunction

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Runs one conversion; conv_first starts with conv_n low alone,
    // poke fires an extra command mid-conversion.
    task automatic do_conv(logic [11:0] s, logic sb, bit conv_first, bit poke);
        sel_n = 1'b1; conv_n = 1'b1; tick();
        sample_in = s; fmt_sb = sb;
        if (conv_first) begin
            conv_n = 1'b0; tick();
            chk("R2 one input low alone", rdy, 1);
        end
        sel_n = 1'b0; conv_n = 1'b0; tick();
        chk("R2 ready falls at start", rdy, 0);
        sample_in = ~s; fmt_sb = ~sb;
        for (int c = 1; c < CONV; c++) begin
            conv_n = (poke && c == 5) ? 1'b0 : 1'b1;
            tick();
        end
        chk(poke ? "R3 busy window kept" : "R2 still busy", rdy, 0);
        conv_n = 1'b1;
        tick();
        chk("R2 ready rises", rdy, 1);
        fmt_sb = sb;
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk("R1 rdy", rdy, 1);
        chk("R1 oe", pdata_oe, 0);
        chk("R1 pdata", pdata, 0);
        chk("R1 sdata", sdata, 0);
        chk("R1 sclk_out", sclk_out, 0);

        for (int i = 0; i < NV; i++) begin
            logic [11:0] s, e;
            logic sb;
            s = VEC[i][11:0]; sb = VEC[i][12];
            e = exp_code(s, sb);
            serial_ext = 1'b1;
            do_conv(s, sb, i == 2, i == 4);
            tick();
            chk("R6 oe on read", pdata_oe, 1);
            chk(sb ? "R5 straight binary" : "R5 twos complement", pdata, e);
            tick();
            chk("R7 reread same", pdata, e);
            chk("R7 sdata untouched", sdata, e[11]);
            sel_n = 1'b1; tick();
            chk("R6 oe off", pdata_oe, 0);
            chk("R6 pdata zero", pdata, 0);
            for (int b = 0; b < 12; b++) begin
                chk("R8 serial bit", sdata, e[11-b]);
                sclk_ext = 1'b1; tick();
                sclk_ext = 1'b0; tick();
            end
            chk("R8 zero fill", sdata, 0);
            sel_n = 1'b0; tick();
            chk("R7 parallel after shift", pdata, e);
        end

        // R4: sample captured at the start edge only
        do_conv(12'h5A3, 1'b1, 0, 1);
        tick();
        chk("R4 captured sample", pdata, 12'h5A3);

        // R9: internal stream of the previous word during the next conversion
        begin
            logic [11:0] a, bw;
            a = 12'hC35; bw = 12'h2E9;
            serial_ext = 1'b1;
            do_conv(a, 1'b1, 0, 0);
            serial_ext = 1'b0;
            sel_n = 1'b1; tick();
            sample_in = bw; fmt_sb = 1'b0;
            sel_n = 1'b0; conv_n = 1'b0; tick();
            conv_n = 1'b1;
            for (int k = 0; k < 24; k++) begin
                if (k > 0) tick();
                chk("R9 stream bit", sdata, a[11 - k/2]);
                chk("R9 bit clock", sclk_out, k % 2);
            end
            tick();
            chk("R9 clock idle after word", sclk_out, 0);
            chk("R9 word drained", sdata, 0);
            repeat (CONV - 25) tick();
            chk("R2 busy while streaming", rdy, 0);
            tick();
            chk("R2 ready after stream", rdy, 1);
            chk("R10 reload msb", sdata, exp_code(bw, 1'b0) >> 11);
            // R11: external clock ignored while deselected
            for (int p = 0; p < 3; p++) begin
                sclk_ext = 1'b1; tick();
                sclk_ext = 1'b0; tick();
            end
            serial_ext = 1'b1;
            for (int b = 0; b < 12; b++) begin
                chk("R11 R10 word intact", sdata, exp_code(bw, 1'b0) >> (11 - b) & 1);
                sclk_ext = 1'b1; tick();
                sclk_ext = 1'b0; tick();
            end
        end

        // R1: reset during a conversion
        sel_n = 1'b1; tick();
        sel_n = 1'b0; conv_n = 1'b0; tick();
        conv_n = 1'b1; repeat (4) tick();
        rst = 1'b1; tick();
        rst = 1'b0; tick();
        chk("R1 rdy after mid reset", rdy, 1);
        chk("R1 pdata cleared", pdata, 0);
        chk("R1 sdata cleared", sdata, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule